// File: doc/BRIEF.md
# Crypto Event Interrupt and DMA Router

This block sits beside a cipher accelerator and turns four level-sensitive engine events into one interrupt line and four DMA request lines. The events are: the engine wants a new context, it can accept an input block, it holds an output block, and it holds a result context (a tag or a final IV). Software sees a read-only event status word, sets a per-event interrupt mask and a configuration word that gates each DMA request. The same configuration word can merge the result-context path into the output-block path, for systems that drain both through one channel.

A fourth word reports when the block's own reset sequence has finished. All outputs are registered, so an event reaches the interrupt and DMA pins one clock after it appears at the input, and leaves them one clock after it clears. Register reads are combinational from a two-bit word address; writes take effect at the next clock edge.

Top module: `cx_evt_router`

## Requirements
- R1: While reset is asserted and after it is released, the mask and configuration words read 0, and `irq_o` and every bit of `dma_req_o` are 0 until software enables a source; with all mask bits 0 no event raises `irq_o`.
- R2: Word address 0 (event status) returns the four event inputs as sampled at the previous clock edge in bits 3:0, with bit 0 context-request, bit 1 input-space, bit 2 output-ready and bit 3 context-ready; bits above read 0 and writes to this address change nothing.
- R3: Word address 1 (interrupt mask) is read/write in bits 3:0 with the same bit layout as the status word; bits above are dropped on write and read 0.
- R4: With the merge option off, `irq_o` is 1 in the cycle after an edge at which any event input was 1 with its mask bit set, and 0 otherwise.
- R5: Word address 2 (configuration) holds the DMA enables at bit 5 input-space, bit 6 output-ready, bit 7 context-request, bit 8 context-ready, and the merge option at bit 9; all other bits are dropped on write and read 0.
- R6: With the merge option off, each `dma_req_o` bit equals its event input ANDed with its DMA enable as sampled at the previous clock edge, so a request falls one cycle after its event falls.
- R7: With the merge option on, `dma_req_o[2]` is (output-ready OR context-ready) ANDed with the bit 6 enable, and `dma_req_o[3]` stays 0 whatever bit 8 holds.
- R8: With the merge option on, a context-ready event raises `irq_o` through mask bit 2, and mask bit 3 has no effect.
- R9: Word address 3 bit 0 reads 0 during reset and for the first 3 clock edges after release, and 1 from the 4th edge on; it ignores writes and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 4 | Engine event levels: 0 context-request, 1 input-space, 2 output-ready, 3 context-ready |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 mask, 2 configuration, 3 reset-done |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | 1 | Combined interrupt request |
| dma_req_o | output | 4 | DMA requests, same bit order as `evt_i` |

## Verification
Single events are walked one source at a time with every mask bit set, which separates a swapped or dropped source in the interrupt combine from a correct one. The same single-event walk with all DMA enables set, then with one enable cleared at a time, shows whether each request line is gated by the right configuration bit rather than a neighbour. The merge option is tried with context-ready alone, with output-ready alone and with the output enable cleared, which tells apart a merge that routes the interrupt, the request, or neither, and one that still honours the ignored enables. A long pseudo-random mix of event levels and register writes, including writes aimed at the read-only words, is compared cycle by cycle against a behavioural model to catch timing slips of one clock.

// File: rtl/cx_evt_pkg.sv
package cx_evt_pkg;

    localparam int SRC_N    = 4;
    localparam int ADDR_W   = 2;

    // source positions inside status, mask and request vectors
    localparam int SRC_CIN  = 0;
    localparam int SRC_DIN  = 1;
    localparam int SRC_DOUT = 2;
    localparam int SRC_COUT = 3;

    // configuration word bit positions
    localparam int CFG_DIN  = 5;
    localparam int CFG_DOUT = 6;
    localparam int CFG_CIN  = 7;
    localparam int CFG_COUT = 8;
    localparam int CFG_FOLD = 9;
    localparam int CFG_W    = CFG_FOLD + 1;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STATUS = 2'd0,
        ADR_MASK   = 2'd1,
        ADR_CFG    = 2'd2,
        ADR_SYS    = 2'd3
    } reg_adr_e;

    typedef struct packed {
        logic             fold;
        logic [SRC_N-1:0] dma_en;   // indexed by source position
    } cfg_t;

    function automatic cfg_t cfg_from_word(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.fold             = w[CFG_FOLD];
        c.dma_en[SRC_CIN]  = w[CFG_CIN];
        c.dma_en[SRC_DIN]  = w[CFG_DIN];
        c.dma_en[SRC_DOUT] = w[CFG_DOUT];
        c.dma_en[SRC_COUT] = w[CFG_COUT];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_to_word(input cfg_t c);
        logic [CFG_W-1:0] w;
        w           = '0;
        w[CFG_FOLD] = c.fold;
        w[CFG_CIN]  = c.dma_en[SRC_CIN];
        w[CFG_DIN]  = c.dma_en[SRC_DIN];
        w[CFG_DOUT] = c.dma_en[SRC_DOUT];
        w[CFG_COUT] = c.dma_en[SRC_COUT];
        return w;
    endfunction

endpackage

// File: rtl/cx_rst_seq.sv
module cx_rst_seq #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);
    localparam int CW = $clog2(DLY + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.done) begin
            if (s_q.cnt == CW'(DLY - 1)) begin
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o = s_q.done;

    // R9: once set, the done flag never drops while out of reset
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> s_q.done);

endmodule

// File: rtl/cx_evt_regs.sv
module cx_evt_regs
    import cx_evt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SRC_N-1:0]  evt_i,
    input  logic              done_i,
    output logic [SRC_N-1:0]  mask_o,
    output cfg_t              cfg_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [SRC_N-1:0] st;
        logic [SRC_N-1:0] mask;
        cfg_t             cfg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.st = evt_i;
        if (wr_en) begin
            case (reg_adr_e'(addr))
                ADR_MASK: r_d.mask = wdata[SRC_N-1:0];
                ADR_CFG:  r_d.cfg  = cfg_from_word(wdata[CFG_W-1:0]);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (reg_adr_e'(addr))
            ADR_STATUS: rdata_o[SRC_N-1:0] = r_q.st;
            ADR_MASK:   rdata_o[SRC_N-1:0] = r_q.mask;
            ADR_CFG:    rdata_o[CFG_W-1:0] = cfg_to_word(r_q.cfg);
            default:    rdata_o[0]         = done_i;
        endcase
    end

    assign mask_o = r_q.mask;
    assign cfg_o  = r_q.cfg;

    // R2: the status word holds what the event pins showed one edge earlier
    a_r2_status_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (r_q.st == $past(evt_i)));

    // R3: the mask only moves on a write aimed at its address
    a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(wr_en) && $past(addr) == ADR_MASK))
            |-> $stable(r_q.mask));

    // R5: the configuration only moves on a write aimed at its address
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(wr_en) && $past(addr) == ADR_CFG))
            |-> $stable(r_q.cfg));

endmodule

// File: rtl/cx_evt_route.sv
module cx_evt_route
    import cx_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] evt_i,
    input  logic [SRC_N-1:0] mask_i,
    input  cfg_t             cfg_i,
    output logic             irq_o,
    output logic [SRC_N-1:0] dma_o
);

    typedef struct packed {
        logic             irq;
        logic [SRC_N-1:0] dma;
    } out_t;

    out_t o_d, o_q;

    // sources as seen by the interrupt combine, after the optional merge
    logic [SRC_N-1:0] irq_src;
    logic [SRC_N-1:0] dma_nxt;

    genvar g;
    generate
        for (g = 0; g < SRC_N; g++) begin : g_src
            if (g == SRC_DOUT) begin : g_dout
                assign irq_src[g] = evt_i[g] | (cfg_i.fold & evt_i[SRC_COUT]);
                assign dma_nxt[g] = (evt_i[g] | (cfg_i.fold & evt_i[SRC_COUT]))
                                    & cfg_i.dma_en[g];
            end else if (g == SRC_COUT) begin : g_cout
                assign irq_src[g] = evt_i[g] & ~cfg_i.fold;
                assign dma_nxt[g] = evt_i[g] & cfg_i.dma_en[g] & ~cfg_i.fold;
            end else begin : g_plain
                assign irq_src[g] = evt_i[g];
                assign dma_nxt[g] = evt_i[g] & cfg_i.dma_en[g];
            end
        end
    endgenerate

    always_comb begin
        o_d     = o_q;
        o_d.irq = |(irq_src & mask_i);
        o_d.dma = dma_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign irq_o = o_q.irq;
    assign dma_o = o_q.dma;

    // R7: merged mode keeps the context-ready request line quiet
    a_r7_fold_cout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_i.fold)) |-> !o_q.dma[SRC_COUT]);

    // R6: a request falls in the cycle after its input-space event falls
    a_r6_din_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_i[SRC_DIN]) |=> !o_q.dma[SRC_DIN]);

    // R1: with an empty mask at the previous edge no interrupt is raised
    a_r1_no_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mask_i) == '0) |-> !o_q.irq);

endmodule

// File: rtl/cx_evt_router.sv
module cx_evt_router
    import cx_evt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DONE_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        evt_i,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic [3:0]        dma_req_o
);

    logic [SRC_N-1:0] mask;
    cfg_t             cfg;
    logic             done;

    cx_rst_seq #(
        .DLY (DONE_DLY)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_o (done)
    );

    cx_evt_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .evt_i   (evt_i),
        .done_i  (done),
        .mask_o  (mask),
        .cfg_o   (cfg),
        .rdata_o (reg_rdata)
    );

    cx_evt_route u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .mask_i (mask),
        .cfg_i  (cfg),
        .irq_o  (irq_o),
        .dma_o  (dma_req_o)
    );

    // R6: context-request line follows its event gated by its enable
    a_r6_cin_req: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dma_req_o[SRC_CIN] ==
                          ($past(evt_i[SRC_CIN]) && $past(cfg.dma_en[SRC_CIN]))));

    // R8: in merged mode a lone context-ready event with only mask bit 3 set stays silent
    a_r8_fold_mask3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg.fold) && $past(mask) == 4'b1000)
            |-> !irq_o);

endmodule

// File: tb/cx_evt_router_bench.sv
module cx_evt_router_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt = '0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [3:0]  dma;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cx_evt_router u_cx_evt_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .reg_we    (we),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_o     (irq),
        .dma_req_o (dma)
    );

    // ---------------- behavioural reference ----------------
    // configuration bit that enables each request line, by line number
    int en_bit [4] = '{7, 5, 6, 8};

    logic [3:0]  m_mask, m_st, m_dma;
    logic [31:0] m_cfg;
    logic        m_irq;
    int          m_edges;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mask = '0; m_cfg = '0; m_st = '0; m_dma = '0; m_irq = 1'b0; m_edges = 0;
        end else begin
            logic       fold;
            logic       nirq;
            logic [3:0] ndma;
            fold = m_cfg[9];
            nirq = 1'b0;
            for (int s = 0; s < 4; s++) begin
                logic en;
                en = (fold && s == 3) ? m_mask[2] : m_mask[s];
                if (evt[s] && en) nirq = 1'b1;
                ndma[s] = evt[s] & m_cfg[en_bit[s]];
            end
            if (fold) begin
                ndma[3] = 1'b0;
                ndma[2] = (evt[2] | evt[3]) & m_cfg[6];
            end
            m_irq = nirq;
            m_dma = ndma;
            m_st  = evt;
            if (we && addr == 2'd1) m_mask = wdata[3:0];
            if (we && addr == 2'd2) m_cfg  = wdata & 32'h0000_03E0;
            m_edges++;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {28'd0, m_st};
            2'd1:    return {28'd0, m_mask};
            2'd2:    return m_cfg;
            default: return {31'd0, (m_edges >= 4)};
        endcase
    endfunction

    function automatic string rd_tag(input logic [1:0] a);
        case (a)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, sampled mid-cycle
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R4/R8 irq", {31'd0, irq}, {31'd0, m_irq});
            chk("R6/R7 dma", {28'd0, dma}, {28'd0, m_dma});
            chk({rd_tag(addr), " rdata"}, rdata, exp_rd(addr));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input logic [3:0] e, input logic w, input logic [1:0] a,
                        input logic [31:0] d);
        @(posedge clk);
        #1;
        evt = e; we = w; addr = a; wdata = d;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        step(evt, 1'b1, a, d);
        step(evt, 1'b0, a, 32'd0);
    endtask

    // wait until registered outputs reflect the last driven inputs
    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; evt = '0; we = 1'b0; addr = 2'd3;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // ---------------- test sequence ----------------
    initial begin
        logic [15:0] lfsr;
        do_reset();
        cmp_on = 1'b1;

        // R1: reset state at the ports
        @(negedge clk);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 dma after reset", {28'd0, dma}, 32'd0);
        // R9: not yet done after 0 edges, then 3 edges, then done after 4
        chk("R9 done at 0 edges", rdata, 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 done at 3 edges", rdata, 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R9 done at 4 edges", rdata, 32'd1);
        // R9: write to the read-only word
        wr(2'd3, 32'h0000_0000);
        @(negedge clk);
        chk("R9 write ignored", rdata, 32'd1);

        // R1: every event active, nothing enabled
        step(4'hF, 1'b0, 2'd0, 32'd0);
        settle();
        chk("R1 masked events no irq", {31'd0, irq}, 32'd0);
        chk("R2 status all set", rdata, 32'h0000_000F);
        // R2: write to status does nothing
        wr(2'd0, 32'hFFFF_FFF0);
        evt = 4'h5;
        settle();
        chk("R2 status after write", rdata, 32'h0000_0005);

        // R3: mask write with junk in high bits
        step(4'h0, 1'b0, 2'd0, 32'd0);
        wr(2'd1, 32'hABCD_E00F);
        @(negedge clk);
        chk("R3 mask readback", rdata, 32'h0000_000F);

        // R4: walk one source at a time
        for (int s = 0; s < 4; s++) begin
            step(4'(1 << s), 1'b0, 2'd1, 32'd0);
            settle();
            chk("R4 single source irq", {31'd0, irq}, 32'd1);
            step(4'h0, 1'b0, 2'd1, 32'd0);
            settle();
            chk("R4 irq clears", {31'd0, irq}, 32'd0);
        end

        // R5: configuration write keeps only defined bits
        wr(2'd2, 32'hFFFF_FDFF);
        @(negedge clk);
        chk("R5 cfg readback", rdata, 32'h0000_01E0);

        // R6: each line follows its event; drop one cycle after event falls
        for (int s = 0; s < 4; s++) begin
            step(4'(1 << s), 1'b0, 2'd2, 32'd0);
            settle();
            chk("R6 request rises", {28'd0, dma}, 32'(1 << s));
            step(4'h0, 1'b0, 2'd2, 32'd0);
            settle();
            chk("R6 request drops", {28'd0, dma}, 32'd0);
        end
        // R6: clear one enable at a time
        for (int s = 0; s < 4; s++) begin
            wr(2'd2, 32'h0000_01E0 & ~(32'd1 << en_bit[s]));
            step(4'hF, 1'b0, 2'd2, 32'd0);
            settle();
            chk("R6 one enable cleared", {28'd0, dma}, 32'(4'hF & ~(4'd1 << s)));
            step(4'h0, 1'b0, 2'd2, 32'd0);
        end

        // R7/R8: merged mode
        wr(2'd2, 32'h0000_03E0);
        wr(2'd1, 32'h0000_0008);
        step(4'h8, 1'b0, 2'd1, 32'd0);
        settle();
        chk("R8 mask bit3 ignored", {31'd0, irq}, 32'd0);
        chk("R7 merged request on line 2", {28'd0, dma}, 32'h0000_0004);
        wr(2'd1, 32'h0000_0004);
        settle();
        chk("R8 context-ready via mask bit2", {31'd0, irq}, 32'd1);
        step(4'h4, 1'b0, 2'd1, 32'd0);
        settle();
        chk("R7 output-ready still on line 2", {28'd0, dma}, 32'h0000_0004);
        wr(2'd2, 32'h0000_03A0);
        step(4'h8, 1'b0, 2'd1, 32'd0);
        settle();
        chk("R7 bit8 ignored when merged", {28'd0, dma}, 32'd0);
        step(4'h0, 1'b0, 2'd1, 32'd0);

        // mixed pseudo-random traffic against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:0], (lfsr[7:5] == 3'd0), lfsr[9:8],
                 {lfsr, lfsr[7:0], lfsr[15:8]});
        end

        // R1: reset in the middle of activity
        do_reset();
        @(negedge clk);
        chk("R1 irq after second reset", {31'd0, irq}, 32'd0);
        chk("R1 dma after second reset", {28'd0, dma}, 32'd0);
        step(4'h0, 1'b0, 2'd2, 32'd0);
        @(negedge clk);
        chk("R1 cfg cleared", rdata, 32'd0);
        step(4'h0, 1'b0, 2'd1, 32'd0);
        @(negedge clk);
        chk("R1 mask cleared", rdata, 32'd0);

        repeat (4) @(posedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule